// File: doc/BRIEF.md
# Asynchronous Pattern Memory Sequencer

This block connects one internal request port to an external asynchronous memory such as a ROM, a NOR flash or an SRAM. Each request is a single 16-bit read or write. The block turns it into one or two external accesses with a 25-bit address, a 16-bit data bus split into separate in, out and enable lines, and active-low output-enable and write-enable strobes. All access lengths are counted in system clocks. Three programmable fields set them: bus-turnaround clocks, first-access clocks and page clocks. A value of zero in any field counts as one clock.

After a read, the page stays open and output-enable stays low. A later read that hits the same page (the address bits from `PB` upward are equal) then costs only the page length. A narrow-bus mode lets the same request port serve an 8-bit memory: each 16-bit transfer becomes two byte accesses, low byte first. An active-low float input hands the memory bus to another master. While it is low, every memory output is released and the sequencer stands still.

Top module: `patmem_ctrl`

## Requirements
- R1: After reset, with `mem_hiz_n` high, `req_ready` is 1, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_en` is 0, `mem_ctl_en` is 1 and `rd_valid` is 0.
- R2: Take F, R and P as the effective turnaround, first-access and page lengths. For a read that does not hit the open page, `mem_oe_n` stays high for F cycles after the accept cycle and then goes low for R cycles. The data on `mem_dq_in` is sampled at the end of the last low cycle. `rd_valid` rises F+R+1 cycles after the accept cycle.
- R3: A read hits the open page when three things hold: the previous request was a read, the bus mode is the same, and the address bits from `PB` (default 3) upward match. On a hit, `mem_oe_n` stays low throughout and `rd_valid` rises P+1 cycles after the accept cycle.
- R4: A value of 0 in `cfg_float`, `cfg_rand` or `cfg_page` gives an effective length of one clock. Any other value v gives v clocks.
- R5: A write runs in three phases. First come F cycles with both strobes high and the data bus not driven. Then come R cycles with `mem_we_n` low, `mem_oe_n` high and the data driven. Last comes one hold cycle with `mem_we_n` high and the data still driven. `req_ready` returns F+R+2 cycles after the accept cycle.
- R6: With `cfg_byte`=1, a read of word address W makes two byte accesses. The first goes to bus address {W[23:0],0} as a full random access. The second goes to {W[23:0],1} as a page access. Each byte is taken from `mem_dq_in[7:0]`, and `rd_data` is {second byte, first byte}. `rd_valid` rises F+R+P+1 cycles after the accept cycle.
- R7: With `cfg_byte`=1, a write makes two write pulses of R cycles each, each followed by its hold cycle. The first puts `req_wdata[7:0]` on {W[23:0],0}. The second puts `req_wdata[15:8]` on {W[23:0],1}. Each byte sits in `mem_dq_out[7:0]` with the upper byte at 0. `req_ready` returns F+2(R+1)+1 cycles after the accept cycle.
- R8: While `mem_hiz_n` is 0, three things hold. `mem_ctl_en`, `mem_dq_en` and `req_ready` are 0. No request is accepted. The sequence in progress is frozen, so each such cycle lengthens it by one.
- R9: A write closes the open page, so the next read is a full random access.
- R10: A read to a different page, or in a different bus mode, is a full random access.
- R11: `rd_valid` is high for exactly one cycle per read. `req_ready` is low from the cycle after an accept until the request is finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_float | input | 2 | Turnaround clocks (0 counts as 1) |
| cfg_rand | input | 4 | First-access clocks (0 counts as 1) |
| cfg_page | input | 3 | Page-access clocks (0 counts as 1) |
| cfg_byte | input | 1 | 1 selects an 8-bit external bus |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted in this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | DW | Read data |
| mem_addr | output | AW | External address |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ctl_en | output | 1 | Drive enable for address and strobes |
| mem_dq_out | output | DW | Data bus value when driving |
| mem_dq_en | output | 1 | Data bus drive enable |
| mem_dq_in | input | DW | Data bus value from memory |
| mem_hiz_n | input | 1 | 0 floats all memory outputs and freezes the sequencer |

## Verification
The bench attacks the cycle counts. A counter that is off by one, or that treats a zero field as zero clocks, moves `rd_valid` or `req_ready` by a cycle. The memory model also returns all ones whenever output-enable is high, so data sampled during turnaround shows up as a wrong word. Page tests check that a write or a page change forces a full access; a design that keeps the page open would return the data early. The narrow-mode tests check byte order and byte addresses, which a swapped lane or a missing address bit would get wrong. The float tests check that a sequence frozen mid-flight ends exactly three cycles late, and that a request held against a floated bus is not taken.

// File: rtl/patmem_pkg.sv
package patmem_pkg;

    localparam int ADDR_W   = 25;
    localparam int DATA_W   = 16;
    localparam int PAGE_LSB = 3;
    localparam int TIM_W    = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FLOAT,
        ST_RAND,
        ST_PAGE,
        ST_WRITE,
        ST_WHOLD
    } seq_state_t;

    typedef struct packed {
        logic [1:0] flt;
        logic [3:0] rnd;
        logic [2:0] pg;
        logic       narrow;
    } tim_cfg_t;

    // Counter preload: a phase of v clocks loads v-1, and 0 behaves as 1.
    function automatic logic [TIM_W-1:0] load_of(input logic [TIM_W-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

endpackage

// File: rtl/patmem_timer.sv
module patmem_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (en) begin
            if (load)
                cnt <= load_val;
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/patmem_seq.sv
module patmem_seq
    import patmem_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int PB = PAGE_LSB
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  tim_cfg_t      cfg,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] bus_addr,
    output logic          bus_oe_n,
    output logic          bus_we_n,
    output logic          bus_dq_drv,
    output logic [DW-1:0] bus_dq,
    input  logic [DW-1:0] bus_dq_in
);

    localparam int HALF  = DW / 2;
    localparam int TAG_W = AW - PB;

    seq_state_t      state, nstate;
    tim_cfg_t        tim;
    logic            op_wr;
    logic            upper;
    logic [AW-1:0]   base;
    logic [DW-1:0]   wbuf;
    logic [HALF-1:0] lo_byte;
    logic            page_open;
    logic            page_narrow;
    logic [TAG_W-1:0] page_tag;

    logic            t_load, t_done;
    logic [TIM_W-1:0] t_val;
    logic            accept, capture, advance, finish_rd;
    logic [AW-1:0]   cur_addr, req_bus;
    logic            hit;

    // Narrow mode: the word address shifts up one and bit 0 picks the byte.
    assign cur_addr = tim.narrow ? {base[AW-2:0], upper} : base;
    assign req_bus  = cfg.narrow ? {req_addr[AW-2:0], 1'b0} : req_addr;
    assign hit      = page_open && !req_write && (page_narrow == cfg.narrow)
                      && (req_bus[AW-1:PB] == page_tag);

    patmem_timer #(.CW(TIM_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .en       (!hold),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    always_comb begin
        nstate    = state;
        t_load    = 1'b0;
        t_val     = '0;
        accept    = 1'b0;
        capture   = 1'b0;
        advance   = 1'b0;
        finish_rd = 1'b0;
        if (!hold) begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        accept = 1'b1;
                        t_load = 1'b1;
                        if (hit) begin
                            nstate = ST_PAGE;
                            t_val  = load_of(TIM_W'(cfg.pg));
                        end else begin
                            nstate = ST_FLOAT;
                            t_val  = load_of(TIM_W'(cfg.flt));
                        end
                    end
                end
                ST_FLOAT: begin
                    if (t_done) begin
                        nstate = op_wr ? ST_WRITE : ST_RAND;
                        t_load = 1'b1;
                        t_val  = load_of(tim.rnd);
                    end
                end
                ST_RAND, ST_PAGE: begin
                    if (t_done) begin
                        capture = 1'b1;
                        if (tim.narrow && !upper) begin
                            nstate  = ST_PAGE;
                            advance = 1'b1;
                            t_load  = 1'b1;
                            t_val   = load_of(TIM_W'(tim.pg));
                        end else begin
                            nstate    = ST_IDLE;
                            finish_rd = 1'b1;
                        end
                    end
                end
                ST_WRITE: begin
                    if (t_done)
                        nstate = ST_WHOLD;
                end
                ST_WHOLD: begin
                    if (tim.narrow && !upper) begin
                        nstate  = ST_WRITE;
                        advance = 1'b1;
                        t_load  = 1'b1;
                        t_val   = load_of(tim.rnd);
                    end else begin
                        nstate = ST_IDLE;
                    end
                end
                default: nstate = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            tim         <= '0;
            op_wr       <= 1'b0;
            upper       <= 1'b0;
            base        <= '0;
            wbuf        <= '0;
            lo_byte     <= '0;
            page_open   <= 1'b0;
            page_narrow <= 1'b0;
            page_tag    <= '0;
            rd_valid    <= 1'b0;
            rd_data     <= '0;
        end else begin
            state    <= nstate;
            rd_valid <= 1'b0;
            if (accept) begin
                op_wr <= req_write;
                tim   <= cfg;
                base  <= req_addr;
                upper <= 1'b0;
                wbuf  <= req_wdata;
                if (req_write)
                    page_open <= 1'b0;
            end
            if (advance)
                upper <= 1'b1;
            if (capture && tim.narrow && !upper)
                lo_byte <= bus_dq_in[HALF-1:0];
            if (finish_rd) begin
                rd_valid    <= 1'b1;
                rd_data     <= tim.narrow ? {bus_dq_in[HALF-1:0], lo_byte} : bus_dq_in;
                page_open   <= 1'b1;
                page_narrow <= tim.narrow;
                page_tag    <= cur_addr[AW-1:PB];
            end
        end
    end

    assign req_ready  = (state == ST_IDLE) && !hold;
    assign bus_addr   = cur_addr;
    assign bus_oe_n   = !((state == ST_RAND) || (state == ST_PAGE) ||
                          ((state == ST_IDLE) && page_open));
    assign bus_we_n   = (state != ST_WRITE);
    assign bus_dq_drv = (state == ST_WRITE) || (state == ST_WHOLD);
    assign bus_dq     = tim.narrow ? {{HALF{1'b0}}, (upper ? wbuf[DW-1:HALF] : wbuf[HALF-1:0])}
                                   : wbuf;

endmodule

// File: rtl/patmem_pins.sv
module patmem_pins #(
    parameter int AW = 25,
    parameter int DW = 16
) (
    input  logic          hiz_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_oe_n,
    input  logic          bus_we_n,
    input  logic          bus_dq_drv,
    input  logic [DW-1:0] bus_dq,
    output logic [AW-1:0] mem_addr,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic          mem_ctl_en,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_en
);

    // A floated bus shows idle strobe levels so a bus keeper sees no pulse.
    assign mem_ctl_en = hiz_n;
    assign mem_dq_en  = hiz_n && bus_dq_drv;
    assign mem_addr   = bus_addr;
    assign mem_oe_n   = bus_oe_n || !hiz_n;
    assign mem_we_n   = bus_we_n || !hiz_n;
    assign mem_dq_out = bus_dq;

endmodule

// File: rtl/patmem_ctrl.sv
module patmem_ctrl
    import patmem_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int PB = PAGE_LSB
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    cfg_float,
    input  logic [3:0]    cfg_rand,
    input  logic [2:0]    cfg_page,
    input  logic          cfg_byte,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic          mem_ctl_en,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_en,
    input  logic [DW-1:0] mem_dq_in,
    input  logic          mem_hiz_n
);

    tim_cfg_t        cfg;
    logic [AW-1:0]   bus_addr;
    logic            bus_oe_n, bus_we_n, bus_dq_drv;
    logic [DW-1:0]   bus_dq;

    assign cfg = '{flt: cfg_float, rnd: cfg_rand, pg: cfg_page, narrow: cfg_byte};

    patmem_seq #(.AW(AW), .DW(DW), .PB(PB)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .hold       (!mem_hiz_n),
        .cfg        (cfg),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .bus_addr   (bus_addr),
        .bus_oe_n   (bus_oe_n),
        .bus_we_n   (bus_we_n),
        .bus_dq_drv (bus_dq_drv),
        .bus_dq     (bus_dq),
        .bus_dq_in  (mem_dq_in)
    );

    patmem_pins #(.AW(AW), .DW(DW)) u_pins (
        .hiz_n      (mem_hiz_n),
        .bus_addr   (bus_addr),
        .bus_oe_n   (bus_oe_n),
        .bus_we_n   (bus_we_n),
        .bus_dq_drv (bus_dq_drv),
        .bus_dq     (bus_dq),
        .mem_addr   (mem_addr),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_ctl_en (mem_ctl_en),
        .mem_dq_out (mem_dq_out),
        .mem_dq_en  (mem_dq_en)
    );

endmodule

// File: rtl/patmem_ctrl_chk.sv
module patmem_ctrl_chk #(
    parameter int AW = 25
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rd_valid,
    input logic [AW-1:0] mem_addr,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic          mem_ctl_en,
    input logic          mem_dq_en,
    input logic          mem_hiz_n
);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n));                                   // R5
    AST_WE_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && mem_ctl_en) |-> mem_dq_en);                     // R5
    AST_READ_SAMPLED: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(!mem_oe_n));                               // R2
    AST_FLOAT_PINS: assert property (@(posedge clk) disable iff (rst)
        !mem_hiz_n |-> (!mem_ctl_en && !mem_dq_en));                  // R8
    AST_FLOAT_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        !mem_hiz_n |-> !req_ready);                                   // R8
    AST_FLOAT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        $past(!mem_hiz_n) |-> $stable(mem_addr));                     // R8
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);                     // R11
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);                                      // R11

endmodule

bind patmem_ctrl patmem_ctrl_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .mem_addr   (mem_addr),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_ctl_en (mem_ctl_en),
    .mem_dq_en  (mem_dq_en),
    .mem_hiz_n  (mem_hiz_n)
);

// File: tb/patmem_ctrl_test.sv
module patmem_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_float = 2'd2;
    logic [3:0]  cfg_rand = 4'd3;
    logic [2:0]  cfg_page = 3'd2;
    logic        cfg_byte = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [24:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [24:0] mem_addr;
    logic        mem_oe_n, mem_we_n, mem_ctl_en, mem_dq_en;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in;
    logic        mem_hiz_n = 1'b1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    // Memory model: word = {~a[7:0], a[7:0]}; all ones while OE is high.
    assign mem_dq_in = mem_oe_n ? 16'hFFFF : {~mem_addr[7:0], mem_addr[7:0]};

    patmem_ctrl uut (
        .clk(clk), .rst(rst),
        .cfg_float(cfg_float), .cfg_rand(cfg_rand), .cfg_page(cfg_page), .cfg_byte(cfg_byte),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_ctl_en(mem_ctl_en), .mem_dq_out(mem_dq_out), .mem_dq_en(mem_dq_en),
        .mem_dq_in(mem_dq_in), .mem_hiz_n(mem_hiz_n)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic set_cfg(input int f, input int r, input int p, input bit narrow);
        @(negedge clk);
        cfg_float = 2'(f); cfg_rand = 4'(r); cfg_page = 3'(p); cfg_byte = narrow;
    endtask

    task automatic run_read(input string req, input logic [24:0] a, input int exp_n,
                            input int exp_oe, input logic [15:0] exp_d);
        int n, oe_low;
        @(negedge clk);
        chk(req, "ready before read", req_ready, 1);
        req_write = 1'b0; req_addr = a; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; n = 1; oe_low = 0;
        while (!rd_valid && n < 200) begin
            if (!mem_oe_n) oe_low++;
            @(negedge clk);
            n++;
        end
        chk(req, "read latency", n, exp_n);
        chk(req, "oe low cycles", oe_low, exp_oe);
        chk(req, "read data", rd_data, exp_d);
        @(negedge clk);
        chk("R11", "valid pulse width", rd_valid, 0);
    endtask

    task automatic run_write(input string req, input logic [24:0] a, input logic [15:0] d,
                             input int exp_n, input int exp_we, input int exp_drv,
                             input logic [24:0] a0, input logic [15:0] d0,
                             input logic [24:0] a1, input logic [15:0] d1, input int exp_pulses);
        int n, we_low, drv, pulses, bad;
        logic prev_low;
        logic [24:0] la;
        logic [15:0] ld;
        logic [24:0] pa [2];
        logic [15:0] pd [2];
        pa[0] = '0; pa[1] = '0; pd[0] = '0; pd[1] = '0;
        la = '0; ld = '0;
        @(negedge clk);
        chk(req, "ready before write", req_ready, 1);
        req_write = 1'b1; req_addr = a; req_wdata = d; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        n = 1; we_low = 0; drv = 0; pulses = 0; bad = 0; prev_low = 1'b0;
        while (!req_ready && n < 200) begin
            if (mem_dq_en) drv++;
            if (!mem_we_n) begin
                we_low++; la = mem_addr; ld = mem_dq_out;
                if (!mem_oe_n || !mem_dq_en) bad++;
            end else if (prev_low) begin
                if (pulses < 2) begin pa[pulses] = la; pd[pulses] = ld; end
                pulses++;
            end
            prev_low = !mem_we_n;
            @(negedge clk);
            n++;
        end
        chk(req, "write length", n, exp_n);
        chk(req, "we low cycles", we_low, exp_we);
        chk(req, "data drive cycles", drv, exp_drv);
        chk(req, "strobe/drive conflicts", bad, 0);
        chk(req, "write pulses", pulses, exp_pulses);
        chk(req, "first write addr", pa[0], a0);
        chk(req, "first write data", pd[0], d0);
        if (exp_pulses > 1) begin
            chk(req, "second write addr", pa[1], a1);
            chk(req, "second write data", pd[1], d1);
        end
    endtask

    task automatic test_reset;
        @(negedge clk);
        chk("R1", "ready", req_ready, 1);
        chk("R1", "oe_n", mem_oe_n, 1);
        chk("R1", "we_n", mem_we_n, 1);
        chk("R1", "dq_en", mem_dq_en, 0);
        chk("R1", "ctl_en", mem_ctl_en, 1);
        chk("R1", "rd_valid", rd_valid, 0);
    endtask

    task automatic test_random_and_page;
        set_cfg(2, 3, 2, 1'b0);
        run_read("R2", 25'h0123450, 6, 3, 16'hAF50);
        chk("R3", "oe held low with page open", mem_oe_n, 0);
        run_read("R3", 25'h0123451, 3, 2, 16'hAE51);
        run_read("R10", 25'h0123458, 6, 3, 16'hA758);
    endtask

    task automatic test_zero_fields;
        set_cfg(0, 0, 0, 1'b0);
        run_read("R4", 25'h0000100, 3, 1, 16'hFF00);
        run_read("R4", 25'h0000102, 2, 1, 16'hFD02);
    endtask

    task automatic test_write_closes_page;
        set_cfg(1, 2, 1, 1'b0);
        run_write("R5", 25'h0000101, 16'hBEEF, 5, 2, 3,
                  25'h0000101, 16'hBEEF, '0, '0, 1);
        run_read("R9", 25'h0000101, 4, 2, 16'hFE01);
    endtask

    task automatic test_narrow;
        set_cfg(1, 2, 1, 1'b1);
        run_read("R6", 25'h0000345, 5, 3, 16'h8B8A);
        run_write("R7", 25'h0000345, 16'hC3A7, 8, 4, 6,
                  25'h000068A, 16'h00A7, 25'h000068B, 16'h00C3, 2);
    endtask

    task automatic test_float;
        int n;
        set_cfg(2, 3, 2, 1'b0);
        @(negedge clk);
        req_write = 1'b0; req_addr = 25'h0100000; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; n = 1;
        while (!rd_valid && n < 200) begin
            if (n == 1) mem_hiz_n = 1'b0;
            if (n == 4) mem_hiz_n = 1'b1;
            #1;
            if (n >= 1 && n <= 3) begin
                chk("R8", "ctl released", mem_ctl_en, 0);
                chk("R8", "dq released", mem_dq_en, 0);
            end
            @(negedge clk);
            n++;
        end
        chk("R8", "frozen read latency", n, 9);
        chk("R8", "frozen read data", rd_data, 16'hFF00);
        // Request held against a floated idle bus must not be taken.
        @(negedge clk);
        mem_hiz_n = 1'b0; req_write = 1'b0; req_addr = 25'h0100001; req_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            #1;
            chk("R8", "ready while floated", req_ready, 0);
            @(negedge clk);
        end
        req_valid = 1'b0; mem_hiz_n = 1'b1;
        run_read("R8", 25'h0100001, 3, 2, 16'hFE01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset;
        test_random_and_page;
        test_zero_fields;
        test_write_closes_page;
        test_narrow;
        test_float;
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule